// File: doc/BRIEF.md
# Link Training Watchdog

This block decides whether a serial link has finished training after the link state machine has been enabled. A one-cycle start strobe arms it. It then ignores the PHY status for a fixed settling interval. After that it samples a 32-bit PHY status word once per poll interval, up to a bounded number of attempts. It stops at the first sample that shows a trained link. If every attempt fails, it looks at the status word one last time, in the cycle after the last poll. If that look also fails, the attempt is declared failed.

A failed attempt raises a failure flag and holds the PHY in reset. It also freezes both debug words, the status word and a second auxiliary word, so that software or a logger can read them afterwards. Both results stay in place until the next start strobe. The settle interval, the poll interval and the attempt limit are parameters counted in clock cycles. The two status bit positions are also parameters. What the individual training states mean is outside this block.

The controller is a single state machine with these states:
- IDLE: after reset.
- SETTLE: the settling wait.
- POLL: poll intervals and their samples.
- FINAL: the extra last look.
- PASSED and FAILED: the results, which hold until restarted.

Its transitions are:
- IDLE to SETTLE on start.
- SETTLE to POLL when the settle timer runs out.
- POLL to PASSED on a good sample.
- POLL to POLL on a bad sample that is not the last attempt.
- POLL to FINAL on a bad last attempt.
- FINAL to PASSED or FINAL to FAILED.
- PASSED or FAILED to SETTLE on start.

Top module: `lnk_train_mon`

## Requirements
- R1: After reset, done_o, pass_o, fail_o and hold_phy_rst_o are 0, and both captured words are 0.
- R2: A status sample counts as good only when bit 4 of dbg_stat_i is 1 and bit 29 is 0. All other bits have no effect, and a word with bit 29 set is bad even when bit 4 is set.
- R3: After the clock edge that takes start_i, the status is not sampled during the next SETTLE_CYC cycles. The first sample is taken on edge SETTLE_CYC+POLL_CYC, counting the start edge as edge 0.
- R4: Poll n (n = 0..MAX_TRIES-1) is taken on edge SETTLE_CYC+(n+1)*POLL_CYC, and there are at most MAX_TRIES polls. At the first good poll, done_o and pass_o are 1 from the next cycle.
- R5: If all polls are bad, one extra sample is taken on edge SETTLE_CYC+MAX_TRIES*POLL_CYC+1. The result is pass if that sample is good and fail otherwise.
- R6: On failure, done_o, fail_o and hold_phy_rst_o are 1. fail_stat_o and fail_aux_o hold the dbg_stat_i and dbg_aux_i values seen at the deciding sample.
- R7: A result stays unchanged until the next start. A start_i pulse while a check is running has no effect on when or how that check ends.
- R8: A start taken from PASSED or FAILED clears done_o, pass_o, fail_o and hold_phy_rst_o in the next cycle, and a new check begins.
- R9: pass_o and fail_o are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Arms a new check, one-cycle strobe |
| dbg_stat_i | input | 32 | PHY status word holding the up and in-training bits |
| dbg_aux_i | input | 32 | Second PHY debug word, captured on failure |
| done_o | output | 1 | A result is available |
| pass_o | output | 1 | Link trained |
| fail_o | output | 1 | Link did not train in time |
| hold_phy_rst_o | output | 1 | Request to hold the PHY in reset after failure |
| fail_stat_o | output | 32 | Status word captured at the failing sample |
| fail_aux_o | output | 32 | Auxiliary word captured at the failing sample |

## Verification
The status word is driven as a window of cycles in which it is good, and the bench predicts the exact edge of the decision from the sampling schedule.

- A word that is good from the start must give a pass on the very first poll edge.
- A word that is good only during settling must give a fail, which shows that the settle interval masks the status.
- A word that is good for a single cycle on a poll edge shows the exact sampling point.
- A word that becomes good only after the last poll separates the final extra look from the polls.
- A word with both status bits set must fail, which shows that the in-training bit vetoes the up bit.
- Start pulses in mid-check and restarts after a failure cover result holding and clearing.

// File: rtl/lnk_mon_pkg.sv
package lnk_mon_pkg;

    typedef enum logic [2:0] {
        MS_IDLE   = 3'd0,
        MS_SETTLE = 3'd1,
        MS_POLL   = 3'd2,
        MS_FINAL  = 3'd3,
        MS_PASSED = 3'd4,
        MS_FAILED = 3'd5
    } mon_state_t;

endpackage

// File: rtl/lnk_status_qual.sv
// Decodes link-good from the status word and freezes both debug words on request.
module lnk_status_qual #(
    parameter int W         = 32,
    parameter int UP_BIT    = 4,
    parameter int TRAIN_BIT = 29
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] stat_i,
    input  logic [W-1:0] aux_i,
    input  logic         clr_i,
    input  logic         cap_i,
    output logic         link_ok_o,
    output logic [W-1:0] cap_stat_o,
    output logic [W-1:0] cap_aux_o
);

    assign link_ok_o = stat_i[UP_BIT] & ~stat_i[TRAIN_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_stat_o <= '0;
            cap_aux_o  <= '0;
        end else if (cap_i) begin
            cap_stat_o <= stat_i;
            cap_aux_o  <= aux_i;
        end else if (clr_i) begin
            cap_stat_o <= '0;
            cap_aux_o  <= '0;
        end
    end

endmodule

// File: rtl/lnk_interval_timer.sv
// Down-counter: load has priority, otherwise it counts down to zero and holds there.
module lnk_interval_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] load_val_i,
    output logic          expired_o
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

    AST_TIMER_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !load_i) |=> expired_o); // R3

endmodule

// File: rtl/lnk_try_counter.sv
// Counts failed poll attempts and flags the last allowed attempt.
module lnk_try_counter #(
    parameter int MAX_TRIES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);

    localparam int CW = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && !last_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last_o = (cnt_q == CW'(MAX_TRIES - 1));

    AST_TRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cnt_q) < MAX_TRIES)); // R4

endmodule

// File: rtl/lnk_train_mon.sv
module lnk_train_mon #(
    parameter int SETTLE_CYC = 2500000,
    parameter int POLL_CYC   = 125000,
    parameter int MAX_TRIES  = 20,
    parameter int W          = 32,
    parameter int UP_BIT     = 4,
    parameter int TRAIN_BIT  = 29
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] dbg_stat_i,
    input  logic [W-1:0] dbg_aux_i,
    output logic         done_o,
    output logic         pass_o,
    output logic         fail_o,
    output logic         hold_phy_rst_o,
    output logic [W-1:0] fail_stat_o,
    output logic [W-1:0] fail_aux_o
);
    import lnk_mon_pkg::*;

    localparam int MAXC = (SETTLE_CYC > POLL_CYC) ? SETTLE_CYC : POLL_CYC;
    localparam int TW   = $clog2(MAXC + 1);
    localparam logic [TW-1:0] SETTLE_LD = TW'(SETTLE_CYC - 1);
    localparam logic [TW-1:0] POLL_LD   = TW'(POLL_CYC - 1);

    mon_state_t    state_q, state_d;
    logic          tmr_load, tmr_expired;
    logic [TW-1:0] tmr_val;
    logic          try_clr, try_inc, try_last;
    logic          cap_en, link_ok;

    lnk_status_qual #(.W(W), .UP_BIT(UP_BIT), .TRAIN_BIT(TRAIN_BIT)) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat_i     (dbg_stat_i),
        .aux_i      (dbg_aux_i),
        .clr_i      (try_clr),
        .cap_i      (cap_en),
        .link_ok_o  (link_ok),
        .cap_stat_o (fail_stat_o),
        .cap_aux_o  (fail_aux_o)
    );

    lnk_interval_timer #(.TW(TW)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_expired)
    );

    lnk_try_counter #(.MAX_TRIES(MAX_TRIES)) u_try (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (try_clr),
        .inc_i  (try_inc),
        .last_o (try_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MS_IDLE;
        else        state_q <= state_d;
    end

    // Next state and datapath controls
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = POLL_LD;
        try_clr  = 1'b0;
        try_inc  = 1'b0;
        cap_en   = 1'b0;
        unique case (state_q)
            MS_IDLE, MS_PASSED, MS_FAILED: begin
                if (start_i) begin
                    state_d  = MS_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = SETTLE_LD;
                    try_clr  = 1'b1;
                end
            end
            MS_SETTLE: begin
                if (tmr_expired) begin
                    state_d  = MS_POLL;
                    tmr_load = 1'b1;
                end
            end
            MS_POLL: begin
                if (tmr_expired) begin
                    if (link_ok) begin
                        state_d = MS_PASSED;
                    end else if (try_last) begin
                        state_d = MS_FINAL;
                    end else begin
                        try_inc  = 1'b1;
                        tmr_load = 1'b1;
                    end
                end
            end
            MS_FINAL: begin
                if (link_ok) begin
                    state_d = MS_PASSED;
                end else begin
                    state_d = MS_FAILED;
                    cap_en  = 1'b1;
                end
            end
            default: state_d = MS_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        done_o         = 1'b0;
        pass_o         = 1'b0;
        fail_o         = 1'b0;
        hold_phy_rst_o = 1'b0;
        unique case (state_q)
            MS_PASSED: begin
                done_o = 1'b1;
                pass_o = 1'b1;
            end
            MS_FAILED: begin
                done_o         = 1'b1;
                fail_o         = 1'b1;
                hold_phy_rst_o = 1'b1;
            end
            MS_IDLE, MS_SETTLE, MS_POLL, MS_FINAL: ;
            default: ;
        endcase
    end

    AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_o && fail_o)); // R9
    AST_PASS_NEEDS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pass_o) |-> $past(link_ok)); // R4
    AST_FAIL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_o) |-> (fail_stat_o == $past(dbg_stat_i) && fail_aux_o == $past(dbg_aux_i))); // R6
    AST_HOLD_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> hold_phy_rst_o); // R6
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(pass_o) && $stable(fail_o))); // R7
    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i) |=> (!done_o && !hold_phy_rst_o)); // R8

endmodule

// File: tb/sim_lnk_train_mon.sv
`timescale 1ns/1ps
module sim_lnk_train_mon;

    localparam int S = 8;
    localparam int P = 4;
    localparam int M = 5;
    localparam logic [31:0] GOOD      = 32'h1234_5670; // bit4=1, bit29=0
    localparam logic [31:0] BAD_DOWN  = 32'h1234_5660; // bit4=0
    localparam logic [31:0] BAD_TRAIN = 32'h3234_5670; // bit4=1, bit29=1

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] dbg_stat_i = '0;
    logic [31:0] dbg_aux_i = '0;
    logic        done_o, pass_o, fail_o, hold_phy_rst_o;
    logic [31:0] fail_stat_o, fail_aux_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    lnk_train_mon #(.SETTLE_CYC(S), .POLL_CYC(P), .MAX_TRIES(M)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .dbg_stat_i(dbg_stat_i), .dbg_aux_i(dbg_aux_i),
        .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o),
        .hold_phy_rst_o(hold_phy_rst_o),
        .fail_stat_o(fail_stat_o), .fail_aux_o(fail_aux_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // Status is good for edge i when g < i <= h, otherwise it shows 'bad'.
    task automatic run_case(input string name, input logic [31:0] bad,
                            input int g, input int h, input int busy_at,
                            input logic [31:0] aux);
        int  exp_lat;
        bit  exp_pass;
        int  lat;
        int  i;
        bit  seen;
        exp_pass = 1'b0;
        exp_lat  = S + M * P + 1;
        for (int n = M - 1; n >= 0; n--) begin
            if (g < S + (n + 1) * P && S + (n + 1) * P <= h) begin
                exp_pass = 1'b1;
                exp_lat  = S + (n + 1) * P;
            end
        end
        if (!exp_pass && g < S + M * P + 1 && S + M * P + 1 <= h) exp_pass = 1'b1;

        @(negedge clk);
        start_i    = 1'b1;
        dbg_aux_i  = aux;
        dbg_stat_i = (g < 0 && 0 <= h) ? GOOD : bad;
        @(posedge clk);
        i = 1;
        seen = 1'b0;
        lat = -1;
        while (!seen && i < 400) begin
            @(negedge clk);
            if (i == 1) begin
                // R8: restart clears the outputs one cycle after the start edge
                check("R8", {name, " done cleared"}, {31'd0, done_o}, 32'd0);
                check("R8", {name, " hold cleared"}, {31'd0, hold_phy_rst_o}, 32'd0);
            end
            if (done_o) begin
                seen = 1'b1;
                lat  = i - 1;
            end else begin
                start_i    = (i == busy_at);
                dbg_stat_i = (g < i && i <= h) ? GOOD : bad;
                @(posedge clk);
                i++;
            end
        end
        start_i = 1'b0;
        check(exp_pass ? "R4" : "R5", {name, " latency"}, 32'(lat), 32'(exp_lat));
        check(exp_pass ? "R4" : "R6", {name, " pass"}, {31'd0, pass_o}, {31'd0, exp_pass});
        check("R6", {name, " fail"}, {31'd0, fail_o}, {31'd0, !exp_pass});
        check("R6", {name, " hold"}, {31'd0, hold_phy_rst_o}, {31'd0, !exp_pass});
        check("R9", {name, " excl"}, {31'd0, pass_o & fail_o}, 32'd0);
        if (!exp_pass) begin
            check("R6", {name, " captured stat"}, fail_stat_o, bad);
            check("R6", {name, " captured aux"}, fail_aux_o, aux);
        end
        // R7: result held while start stays low
        dbg_stat_i = ~dbg_stat_i;
        repeat (10) @(negedge clk);
        check("R7", {name, " done held"}, {31'd0, done_o}, 32'd1);
        check("R7", {name, " pass held"}, {31'd0, pass_o}, {31'd0, exp_pass});
    endtask

    task automatic t_reset();
        check("R1", "done", {31'd0, done_o}, 32'd0);
        check("R1", "pass", {31'd0, pass_o}, 32'd0);
        check("R1", "fail", {31'd0, fail_o}, 32'd0);
        check("R1", "hold", {31'd0, hold_phy_rst_o}, 32'd0);
        check("R1", "cap stat", fail_stat_o, 32'd0);
        check("R1", "cap aux", fail_aux_o, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_case("R2 R3 good from start", BAD_DOWN, -1, 1000, -1, 32'hA000_0001);
        run_case("R4 good on one poll edge", BAD_DOWN, S + 2 * P - 1, S + 2 * P, -1, 32'hA000_0002);
        run_case("R4 good later", BAD_DOWN, S + 3 * P, 1000, -1, 32'hA000_0003);
        run_case("R5 final rescue", BAD_DOWN, S + M * P, 1000, -1, 32'hA000_0004);
        run_case("R2 training veto", BAD_TRAIN, 1000, 1000, -1, 32'hA000_0005);
        run_case("R8 restart after fail", BAD_DOWN, -1, 1000, -1, 32'hA000_0006);
        run_case("R3 good only in settle", BAD_DOWN, -1, S + P - 1, -1, 32'hA000_0007);
        run_case("R7 busy start ignored", BAD_DOWN, S + P, 1000, S + 2, 32'hA000_0008);
        run_case("R7 busy start in fail", BAD_DOWN, 1000, 1000, S + 3 * P, 32'hA000_0009);
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule